// File: doc/BRIEF.md
# GPIB Parallel Poll Responder

This block is the device-side parallel poll function of an IEEE-488 talker/listener. It watches the attention (ATN) and end-or-identify (EOI) lines and a flag that says whether the local interface is the controller in charge. When the bus identifies a parallel poll, the block enters its poll state. It then ORs a response byte, which the host has loaded in advance, onto the DIO byte that the rest of the interface drives.

The host loads the response with a single-cycle write strobe. The response storage has two stages. Every write lands in a staging register. While no poll is running, the write also reaches the driven register at once. While a poll runs, the driven byte is frozen, and the staged value is copied across when the next poll starts. Outside a poll the block adds nothing to DIO. Decoding of the configure and unconfigure commands belongs elsewhere.

Top module: `gpib_ppoll_resp`

## Requirements
- R1: After reset `poll_active` is 0 and both response registers hold zero, so a poll that starts with no prior write ORs 8'h00 onto `dio_in`.
- R2: When `poll_active` is 0 and, at a rising clock edge, `atn` = 1, `eoi` = 1, `ctrl_active` = 0 and `soft_rst` = 0, then `poll_active` is 1 after that edge.
- R3: If `ctrl_active` = 1, `soft_rst` = 1, `atn` = 0 or `eoi` = 0 at the edge, no poll begins.
- R4: When `poll_active` is 1, any of `soft_rst` = 1, `atn` = 0, `eoi` = 0 or `ctrl_active` = 1 at an edge clears `poll_active` after that edge.
- R5: A write made while no poll is active is the byte driven when the next poll begins.
- R6: A write made during a poll leaves the driven byte unchanged for the rest of that poll. The written value is driven from the next poll onward.
- R7: When a write and poll entry fall on the same edge, the newly written byte is driven during that poll.
- R8: While `poll_active` is 1, `dio_out` = `dio_in` | response. While it is 0, `dio_out` = `dio_in` with no response bits added. The combinational output path is used with default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset of the interface, forces standby |
| atn | input | 1 | Synchronized ATN, active high |
| eoi | input | 1 | Synchronized EOI, active high |
| ctrl_active | input | 1 | Local interface is the active controller |
| wr_en | input | 1 | Host write strobe for the response byte |
| wr_data | input | DATA_W | Response byte written by the host |
| dio_in | input | DATA_W | Byte driven by the other bus functions |
| dio_out | output | DATA_W | `dio_in` with the response ORed in during a poll |
| poll_active | output | 1 | Parallel poll state is active |

## Verification
Two functions can meet on one clock edge: a host write and the entry into a poll. The bench provokes this by raising ATN and EOI on the same edge that carries a write strobe with a new byte. The poll that follows must drive the new byte and not the older staged one. The opposite ordering is also exercised: a write is made in mid-poll, and the bench confirms that the driven byte does not move until a later poll begins.

// File: rtl/gpib_pp_pkg.sv
package gpib_pp_pkg;
   typedef enum logic {
      PP_STANDBY = 1'b0,
      PP_ACTIVE  = 1'b1
   } pp_state_e;
endpackage

// File: rtl/ppoll_fsm.sv
module ppoll_fsm
   import gpib_pp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic atn,
   input  logic eoi,
   input  logic ctrl_active,
   output logic enter,
   output logic active
);
   pp_state_e state_q, state_d;
   logic      identify;

   // Poll identified on the bus while acting as a device
   assign identify = atn && eoi && !ctrl_active && !soft_rst;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PP_STANDBY: if (identify)  state_d = PP_ACTIVE;
         PP_ACTIVE:  if (!identify) state_d = PP_STANDBY;
         default:                   state_d = PP_STANDBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PP_STANDBY;
      else        state_q <= state_d;
   end

   assign enter  = (state_q == PP_STANDBY) && (state_d == PP_ACTIVE);
   assign active = (state_q == PP_ACTIVE);
endmodule

// File: rtl/ppoll_regs.sv
module ppoll_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              hold,
   input  logic              load,
   output logic [DATA_W-1:0] resp
);
   logic [DATA_W-1:0] stage_q, stage_d, drive_q, drive_d;

   assign stage_d = wr_en ? wr_data : stage_q;

   always_comb begin
      drive_d = drive_q;
      if (load)               drive_d = stage_d;  // newest value wins on entry
      else if (!hold && wr_en) drive_d = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         drive_q <= '0;
      end else begin
         stage_q <= stage_d;
         drive_q <= drive_d;
      end
   end

   assign resp = drive_q;
endmodule

// File: rtl/ppoll_merge.sv
module ppoll_merge #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [DATA_W-1:0] resp,
   input  logic [DATA_W-1:0] dio_in,
   output logic [DATA_W-1:0] dio_out
);
   logic [DATA_W-1:0] merged;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign merged[b] = dio_in[b] | (active & resp[b]);
   end

   if (OUT_REG) begin : g_flop
      logic [DATA_W-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= '0;
         else        out_q <= merged;
      end
      assign dio_out = out_q;
   end else begin : g_comb
      assign dio_out = merged;
   end
endmodule

// File: rtl/gpib_ppoll_resp.sv
module gpib_ppoll_resp #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              atn,
   input  logic              eoi,
   input  logic              ctrl_active,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] dio_in,
   output logic [DATA_W-1:0] dio_out,
   output logic              poll_active
);
   localparam int MAX_W = 64;

   if (DATA_W < 1 || DATA_W > MAX_W) begin : g_bad_width
      $error("gpib_ppoll_resp: DATA_W out of range");
   end

   logic              enter;
   logic [DATA_W-1:0] resp;

   ppoll_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .atn         (atn),
      .eoi         (eoi),
      .ctrl_active (ctrl_active),
      .enter       (enter),
      .active      (poll_active)
   );

   ppoll_regs #(.DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .hold    (poll_active),
      .load    (enter),
      .resp    (resp)
   );

   ppoll_merge #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (poll_active),
      .resp    (resp),
      .dio_in  (dio_in),
      .dio_out (dio_out)
   );
endmodule

// File: rtl/gpib_ppoll_resp_chk.sv
module gpib_ppoll_resp_chk #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              atn,
   input logic              eoi,
   input logic              ctrl_active,
   input logic [DATA_W-1:0] dio_in,
   input logic [DATA_W-1:0] dio_out,
   input logic              poll_active
);
   AST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (!poll_active && atn && eoi && !ctrl_active && !soft_rst) |=> poll_active); // R2

   AST_NO_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (!poll_active && (ctrl_active || soft_rst || !atn || !eoi)) |=> !poll_active); // R3

   AST_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_active && (soft_rst || !atn || !eoi || ctrl_active)) |=> !poll_active); // R4

   if (!OUT_REG) begin : g_comb_chk
      AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         !poll_active |-> (dio_out == dio_in)); // R8

      AST_SUPERSET: assert property (@(posedge clk) disable iff (!rst_n)
         poll_active |-> ((dio_out & dio_in) == dio_in)); // R8

      AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         (poll_active && $past(poll_active) && dio_in == '0 && $past(dio_in) == '0)
            |-> $stable(dio_out)); // R6
   end
endmodule

bind gpib_ppoll_resp gpib_ppoll_resp_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .soft_rst    (soft_rst),
   .atn         (atn),
   .eoi         (eoi),
   .ctrl_active (ctrl_active),
   .dio_in      (dio_in),
   .dio_out     (dio_out),
   .poll_active (poll_active)
);

// File: tb/gpib_ppoll_resp_test.sv
`timescale 1ns/1ps
module gpib_ppoll_resp_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         soft_rst = 1'b0, atn = 1'b0, eoi = 1'b0, ctrl_active = 1'b0, wr_en = 1'b0;
   logic [W-1:0] wr_data = '0, dio_in = '0;
   logic [W-1:0] dio_out;
   logic         poll_active;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic         act;
      logic [W-1:0] out;
      string        tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   gpib_ppoll_resp #(.DATA_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .atn(atn), .eoi(eoi),
      .ctrl_active(ctrl_active), .wr_en(wr_en), .wr_data(wr_data),
      .dio_in(dio_in), .dio_out(dio_out), .poll_active(poll_active)
   );

   task automatic judge(input logic act, input logic [W-1:0] out, input string tag);
      checks++;
      if (poll_active !== act || dio_out !== out) begin
         fails++;
         $display("FAIL %s: poll_active=%b dio_out=%h expected poll_active=%b dio_out=%h",
                  tag, poll_active, dio_out, act, out);
      end
   endtask

   // Driver: apply inputs for one edge and queue the result expected after it
   task automatic step(input logic a, input logic e, input logic c, input logic s,
                       input logic we, input logic [W-1:0] wd, input logic [W-1:0] din,
                       input logic x_act, input logic [W-1:0] x_out, input string tag);
      exp_t item;
      @(negedge clk);
      atn = a; eoi = e; ctrl_active = c; soft_rst = s;
      wr_en = we; wr_data = wd; dio_in = din;
      item.act = x_act; item.out = x_out; item.tag = tag;
      sb.push_back(item);
   endtask

   // Monitor: compare just after each edge, while inputs are still stable
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            judge(it.act, it.out, it.tag);
         end
      end
   end

   initial begin
      #300000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      dio_in = 8'h5A;
      #1;
      judge(1'b0, 8'h5A, "R1 reset state");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: first poll with no write drives zero
      step(1,1,0,0, 0,8'h00,8'h00, 1,8'h00, "R1 cleared response");
      step(0,1,0,0, 0,8'h00,8'h00, 0,8'h00, "R4 exit on atn low");
      step(0,0,0,0, 1,8'hA5,8'h00, 0,8'h00, "R5 standby write not driven");
      step(1,1,0,0, 0,8'h00,8'h10, 1,8'hB5, "R5 R8 staged byte ORed");
      step(1,1,0,0, 1,8'h3C,8'h10, 1,8'hB5, "R6 mid-poll write ignored");
      step(1,1,0,0, 0,8'h00,8'h00, 1,8'hA5, "R6 driven byte frozen");
      step(1,0,0,0, 0,8'h00,8'h00, 0,8'h00, "R4 exit on eoi low");
      step(1,1,0,0, 0,8'h00,8'h00, 1,8'h3C, "R6 deferred byte on next poll");
      step(1,1,1,0, 0,8'h00,8'h00, 0,8'h00, "R4 exit on controller");
      step(1,1,1,0, 0,8'h00,8'h00, 0,8'h00, "R3 no entry as controller");
      step(1,1,0,1, 0,8'h00,8'h00, 0,8'h00, "R3 no entry under soft reset");
      step(1,1,0,0, 0,8'h00,8'h00, 1,8'h3C, "R2 entry");
      step(1,1,0,1, 0,8'h00,8'h00, 0,8'h00, "R4 exit on soft reset");
      step(0,0,0,0, 1,8'hC3,8'h00, 0,8'h00, "R5 standby write");
      step(1,1,0,0, 1,8'h81,8'h00, 1,8'h81, "R7 write with entry");
      step(0,0,0,0, 0,8'h00,8'h42, 0,8'h42, "R8 idle passthrough");
      step(1,0,0,0, 0,8'h00,8'h42, 0,8'h42, "R3 no entry without eoi");
      step(1,1,0,0, 0,8'h00,8'h04, 1,8'h85, "R2 R8 re-entry OR");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule